// File: doc/BRIEF.md
# SDRAM Command Timing Monitor

A passive observer that sits beside an SDRAM controller and watches the command pins, bank address, address bus and clock enable on every rising clock edge. It never drives the bus. For each of the four internal banks it keeps an open or closed state and small saturating counters that measure how many clocks have passed since that bank was last activated and since it was last closed. It also keeps counters for the last activate to any bank, the last mode register write and the last refresh.

When the observed traffic breaks one of the timing or ordering rules, the monitor sets a sticky error bit. Each bit can be disabled through a mask input. It also records which error came first and the cycle on which it happened, and holds that record until software or a test harness pulses a synchronous clear. The burst length used to follow auto-precharge bursts is taken from the address bits of the most recent mode register write. All minimum spacings are parameters, given in clocks. The refresh interval is an input, so a bench can shorten it.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: A command is taken only on an edge where `cke` is high and `cs_n` is low. The pattern {ras_n,cas_n,we_n} decodes as follows: 000 mode set, 001 refresh, 011 activate, 101 read, 100 write, 010 precharge, 110 burst stop, 111 no-op. When `cs_n` is high or `cke` is low, no command is taken.
- R2: Error bit 0 is set by an activate to a bank whose previous activate was fewer than TRC (9) clocks earlier.
- R3: Error bit 1 is set by an activate that comes fewer than TRRD (2) clocks after an activate to a different bank.
- R4: Error bit 2 is set by a read or write to an open bank fewer than TRCD (3) clocks after that bank's activate.
- R5: Error bit 3 is set by a precharge that closes an open bank fewer than TRAS (6) clocks after its activate.
- R6: Error bit 4 is set by an activate fewer than TRP (3) clocks after the bank was closed. A bank is closed either by a precharge or by the end of an auto-precharge burst.
- R7: Error bit 5 is set by a mode set or a refresh while any bank is open. A precharge with addr[10] high closes all banks, whatever the bank address.
- R8: Error bit 6 is set by any command other than a no-op issued fewer than TMRD (2) clocks after a mode set. A deselected cycle is not a command.
- R9: Error bit 7 is set by a read or write to a bank while an auto-precharge burst on that bank is still running. A read or write with addr[10] high starts such a burst. The burst lasts BL clocks. BL comes from addr[2:0] of the last mode set: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, 7 gives PAGE_LEN, and any other value gives 1. After reset BL is 1. The bank closes BL clocks after the command.
- R10: Error bit 8 is raised when more than `refresh_limit` clocks pass after a refresh without the next one. It is raised on clock limit+1 after that refresh. Nothing is checked before the first refresh.
- R11: A bit of `err_flags` is visible on the cycle after the offending command, and only if the matching `err_mask` bit is 1. It stays set until `clear` is sampled high.
- R12: `first_code` is the index of the first error plus 1; when several errors occur together, the lowest index wins. `first_cycle` is the cycle count of the offending command, counting 0 at the first edge after reset release. Both values and `first_valid` are frozen until `clear`.
- R13: An activate opens its bank. A precharge that addresses the bank, or has addr[10] high, closes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Observed clock enable |
| cs_n | input | 1 | Observed chip select |
| ras_n | input | 1 | Observed row strobe |
| cas_n | input | 1 | Observed column strobe |
| we_n | input | 1 | Observed write enable |
| ba | input | BA_W (2) | Observed bank address |
| addr | input | ADDR_W (13) | Observed address bus |
| refresh_limit | input | REF_W (16) | Longest allowed gap between refreshes, in clocks |
| err_mask | input | 9 | Per-bit enable of the error flags |
| clear | input | 1 | Synchronous clear of flags and first-error record |
| err_flags | output | 9 | Sticky error bits |
| first_valid | output | 1 | A first error has been recorded |
| first_code | output | 4 | Index plus 1 of the first error |
| first_cycle | output | CYC_W (32) | Cycle count of the first error |

## Verification
The bench sweeps the spacing between an activate, a precharge and a second activate over every pair of gaps up to 12 clocks. It derives the expected combination of the row-cycle, active-time and precharge-time bits arithmetically, so a comparison that is off by one (`<=` for `<`) shows up as a wrong bit at exactly one gap. For burst lengths 1, 2, 4 and 8 it moves a second read across the auto-precharge burst, which catches a mis-decoded length or a burst window that ends one clock early. It also measures the re-open delay after the burst ends. The remaining cases are:
- the refresh gap on both sides of the limit, where an exclusive bound would flag a gap equal to the limit;
- a precharge to all banks aimed at a different bank, which a design that honours the bank address would leave open;
- deselected cycles that carry a mode-set pattern;
- masked errors, and the first-error record after two violations.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

   typedef enum logic [2:0] {
      C_IDLE, C_MRS, C_REF, C_ACT, C_RD, C_WR, C_PRE, C_BST
   } cmd_e;

   localparam int NUM_ERR  = 9;
   localparam int E_TRC    = 0;
   localparam int E_TRRD   = 1;
   localparam int E_TRCD   = 2;
   localparam int E_TRAS   = 3;
   localparam int E_TRP    = 4;
   localparam int E_OPEN   = 5;
   localparam int E_TMRD   = 6;
   localparam int E_APBUSY = 7;
   localparam int E_REFGAP = 8;

   function automatic int unsigned burst_of(input logic [2:0] code, input int unsigned page);
      case (code)
         3'd1:    return 2;
         3'd2:    return 4;
         3'd3:    return 8;
         3'd7:    return page;
         default: return 1;
      endcase
   endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
   import sdram_mon_pkg::*;
(
   input  logic cke,
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output cmd_e cmd
);
   always_comb begin
      if (!cke || cs_n) begin
         cmd = C_IDLE;
      end else begin
         case ({ras_n, cas_n, we_n})
            3'b000:  cmd = C_MRS;
            3'b001:  cmd = C_REF;
            3'b011:  cmd = C_ACT;
            3'b101:  cmd = C_RD;
            3'b100:  cmd = C_WR;
            3'b010:  cmd = C_PRE;
            3'b110:  cmd = C_BST;
            default: cmd = C_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
   import sdram_mon_pkg::*;
#(
   parameter int TRC  = 9,
   parameter int TRAS = 6,
   parameter int TRCD = 3,
   parameter int TRP  = 3,
   parameter int CW   = 4,
   parameter int BLW  = 10
)(
   input  logic           clk,
   input  logic           rst_n,
   input  cmd_e           cmd,
   input  logic           sel,
   input  logic           ap,
   input  logic [BLW-1:0] blen,
   output logic           open_o,
   output logic           v_trc,
   output logic           v_trcd,
   output logic           v_tras,
   output logic           v_trp,
   output logic           v_apbusy
);
   localparam logic [CW-1:0] SAT   = {CW{1'b1}};
   localparam logic [CW-1:0] L_TRC = CW'(TRC);
   localparam logic [CW-1:0] L_TRAS = CW'(TRAS);
   localparam logic [CW-1:0] L_TRCD = CW'(TRCD);
   localparam logic [CW-1:0] L_TRP = CW'(TRP);

   logic [CW-1:0]  act_cnt, pre_cnt;
   logic [BLW-1:0] rem;
   logic           is_open, ap_pend;
   logic           act_hit, rw_hit, pre_hit, ap_done;

   assign act_hit = (cmd == C_ACT) && sel;
   assign rw_hit  = ((cmd == C_RD) || (cmd == C_WR)) && sel;
   assign pre_hit = (cmd == C_PRE) && (sel || ap);
   assign ap_done = ap_pend && (rem == '0);

   assign v_trc    = act_hit && (act_cnt < L_TRC);
   assign v_trp    = act_hit && (pre_cnt < L_TRP);
   assign v_trcd   = rw_hit && is_open && (act_cnt < L_TRCD);
   assign v_tras   = pre_hit && is_open && (act_cnt < L_TRAS);
   assign v_apbusy = rw_hit && ap_pend && (rem != '0);
   assign open_o   = is_open;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_cnt <= SAT;
         pre_cnt <= SAT;
         is_open <= 1'b0;
         ap_pend <= 1'b0;
         rem     <= '0;
      end else begin
         act_cnt <= (act_cnt == SAT) ? SAT : act_cnt + 1'b1;
         pre_cnt <= (pre_cnt == SAT) ? SAT : pre_cnt + 1'b1;
         if (act_hit) begin
            is_open <= 1'b1;
            act_cnt <= CW'(1);
         end
         if ((pre_hit && is_open) || ap_done) begin
            is_open <= 1'b0;
            pre_cnt <= CW'(1);
            ap_pend <= 1'b0;
         end else if (ap_pend) begin
            rem <= rem - 1'b1;
         end
         if (rw_hit && ap && is_open && !ap_pend) begin
            ap_pend <= 1'b1;
            rem     <= blen - 1'b1;
         end
      end
   end

   assert_act_opens_R13: assert property (@(posedge clk) disable iff (!rst_n)
      act_hit |=> open_o);
   assert_pre_closes_R13: assert property (@(posedge clk) disable iff (!rst_n)
      pre_hit |=> !open_o);

endmodule

// File: rtl/sdram_err_log.sv
module sdram_err_log #(
   parameter int NERR   = 9,
   parameter int CODE_W = 4,
   parameter int CYC_W  = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic [NERR-1:0]   viol,
   input  logic [NERR-1:0]   mask,
   input  logic [CYC_W-1:0]  cyc,
   output logic [NERR-1:0]   flags,
   output logic              first_valid,
   output logic [CODE_W-1:0] first_code,
   output logic [CYC_W-1:0]  first_cycle
);
   logic [NERR-1:0]   hits;
   logic [CODE_W-1:0] pick;

   assign hits = viol & mask;

   always_comb begin
      pick = '0;
      for (int i = NERR - 1; i >= 0; i--) begin
         if (hits[i]) pick = CODE_W'(i + 1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         flags       <= '0;
         first_valid <= 1'b0;
         first_code  <= '0;
         first_cycle <= '0;
      end else begin
         flags <= flags | hits;
         if (!first_valid && (|hits)) begin
            first_valid <= 1'b1;
            first_code  <= pick;
            first_cycle <= cyc;
         end
      end
   end

   assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> ((flags & $past(flags)) == $past(flags)));
   assert_first_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (first_valid && !clear) |=> ($stable(first_code) && $stable(first_cycle)));
   assert_first_flagged_R12: assert property (@(posedge clk) disable iff (!rst_n)
      first_valid |-> flags[first_code - 1'b1]);

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
   import sdram_mon_pkg::*;
#(
   parameter int NBANK     = 4,
   parameter int ADDR_W    = 13,
   parameter int AP_BIT    = 10,
   parameter int TRC       = 9,
   parameter int TRRD      = 2,
   parameter int TRCD      = 3,
   parameter int TRAS      = 6,
   parameter int TRP       = 3,
   parameter int TMRD      = 2,
   parameter int PAGE_LEN  = 512,
   parameter int REF_W     = 16,
   parameter int CYC_W     = 32,
   parameter bit REF_CHECK = 1'b1,
   localparam int BA_W     = $clog2(NBANK),
   localparam int CODE_W   = $clog2(NUM_ERR + 1)
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cke,
   input  logic               cs_n,
   input  logic               ras_n,
   input  logic               cas_n,
   input  logic               we_n,
   input  logic [BA_W-1:0]    ba,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [REF_W-1:0]   refresh_limit,
   input  logic [NUM_ERR-1:0] err_mask,
   input  logic               clear,
   output logic [NUM_ERR-1:0] err_flags,
   output logic               first_valid,
   output logic [CODE_W-1:0]  first_code,
   output logic [CYC_W-1:0]   first_cycle
);
   localparam int TMAX0 = (TRC > TRAS) ? TRC : TRAS;
   localparam int TMAX1 = (TMAX0 > TRRD) ? TMAX0 : TRRD;
   localparam int TMAX2 = (TMAX1 > TMRD) ? TMAX1 : TMRD;
   localparam int TMAX  = (TMAX2 > TRP) ? TMAX2 : TRP;
   localparam int CW    = $clog2(TMAX + 1);
   localparam int BLW   = $clog2(PAGE_LEN + 1);
   localparam logic [CW-1:0] SAT    = {CW{1'b1}};
   localparam logic [CW-1:0] L_TRRD = CW'(TRRD);
   localparam logic [CW-1:0] L_TMRD = CW'(TMRD);

   if (NBANK != (1 << BA_W)) begin : g_bad_nbank
      $error("NBANK must be a power of two");
   end
   if ((TRCD > TRAS) || (TRAS > TRC) || (TRRD < 1) || (TRP < 1)) begin : g_bad_timing
      $error("timing parameters out of order");
   end
   if ((AP_BIT >= ADDR_W) || (ADDR_W < 3)) begin : g_bad_addr
      $error("address width too small");
   end
   if (PAGE_LEN < 8) begin : g_bad_page
      $error("PAGE_LEN must be at least 8");
   end

   cmd_e               cmd;
   logic               ap;
   logic [NBANK-1:0]   b_open, b_trc, b_trcd, b_tras, b_trp, b_ap;
   logic [CW-1:0]      rrd_cnt, mrd_cnt;
   logic [BA_W-1:0]    last_ba;
   logic [BLW-1:0]     blen;
   logic [CYC_W-1:0]   cyc;
   logic [NUM_ERR-1:0] viol;
   logic               v_rrd, v_open, v_mrd, v_ref;
   logic               unused_addr;

   assign ap          = addr[AP_BIT];
   assign unused_addr = ^addr;

   sdram_cmd_decode u_dec (
      .cke   (cke),
      .cs_n  (cs_n),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .we_n  (we_n),
      .cmd   (cmd)
   );

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      sdram_bank_track #(
         .TRC (TRC), .TRAS (TRAS), .TRCD (TRCD), .TRP (TRP),
         .CW (CW), .BLW (BLW)
      ) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .cmd      (cmd),
         .sel      (ba == BA_W'(b)),
         .ap       (ap),
         .blen     (blen),
         .open_o   (b_open[b]),
         .v_trc    (b_trc[b]),
         .v_trcd   (b_trcd[b]),
         .v_tras   (b_tras[b]),
         .v_trp    (b_trp[b]),
         .v_apbusy (b_ap[b])
      );
   end

   assign v_rrd  = (cmd == C_ACT) && (ba != last_ba) && (rrd_cnt < L_TRRD);
   assign v_open = ((cmd == C_MRS) || (cmd == C_REF)) && (|b_open);
   assign v_mrd  = (cmd != C_IDLE) && (mrd_cnt < L_TMRD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rrd_cnt <= SAT;
         mrd_cnt <= SAT;
         last_ba <= '0;
         blen    <= BLW'(1);
         cyc     <= '0;
      end else begin
         cyc     <= cyc + 1'b1;
         rrd_cnt <= (rrd_cnt == SAT) ? SAT : rrd_cnt + 1'b1;
         mrd_cnt <= (mrd_cnt == SAT) ? SAT : mrd_cnt + 1'b1;
         if (cmd == C_ACT) begin
            rrd_cnt <= CW'(1);
            last_ba <= ba;
         end
         if (cmd == C_MRS) begin
            mrd_cnt <= CW'(1);
            blen    <= BLW'(burst_of(addr[2:0], PAGE_LEN));
         end
      end
   end

   if (REF_CHECK) begin : g_ref
      logic [REF_W-1:0] ref_cnt;
      logic             ref_armed;
      assign v_ref = ref_armed && (ref_cnt > refresh_limit);
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ref_cnt   <= '0;
            ref_armed <= 1'b0;
         end else begin
            ref_cnt <= (&ref_cnt) ? ref_cnt : ref_cnt + 1'b1;
            if (v_ref) ref_armed <= 1'b0;
            if (cmd == C_REF) begin
               ref_cnt   <= REF_W'(1);
               ref_armed <= 1'b1;
            end
         end
      end
      assert_refgap_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (v_ref && (cmd != C_REF)) |=> !v_ref);
   end else begin : g_noref
      logic unused_limit;
      assign unused_limit = ^refresh_limit;
      assign v_ref = 1'b0;
   end

   always_comb begin
      viol           = '0;
      viol[E_TRC]    = |b_trc;
      viol[E_TRRD]   = v_rrd;
      viol[E_TRCD]   = |b_trcd;
      viol[E_TRAS]   = |b_tras;
      viol[E_TRP]    = |b_trp;
      viol[E_OPEN]   = v_open;
      viol[E_TMRD]   = v_mrd;
      viol[E_APBUSY] = |b_ap;
      viol[E_REFGAP] = v_ref;
   end

   sdram_err_log #(.NERR (NUM_ERR), .CODE_W (CODE_W), .CYC_W (CYC_W)) u_log (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear       (clear),
      .viol        (viol),
      .mask        (err_mask),
      .cyc         (cyc),
      .flags       (err_flags),
      .first_valid (first_valid),
      .first_code  (first_code),
      .first_cycle (first_cycle)
   );

   assert_one_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke || cs_n) |-> !$countones(viol[E_TRAS:E_TRC]));

endmodule

// File: tb/sdram_cmd_monitor_bench.sv
module sdram_cmd_monitor_bench;
   localparam int PERIOD = 10;
   localparam logic [3:0] K_MRS = 4'b0000;
   localparam logic [3:0] K_REF = 4'b0001;
   localparam logic [3:0] K_ACT = 4'b0011;
   localparam logic [3:0] K_RD  = 4'b0101;
   localparam logic [3:0] K_WR  = 4'b0100;
   localparam logic [3:0] K_PRE = 4'b0010;
   localparam logic [3:0] K_NOP = 4'b0111;
   localparam logic [3:0] K_DES = 4'b1000;
   localparam int AP = 1 << 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cke = 1'b1;
   logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [1:0]  ba = '0;
   logic [12:0] addr = '0;
   logic [15:0] refresh_limit = 16'd1040;
   logic [8:0]  err_mask = '1;
   logic        clear = 1'b0;
   logic [8:0]  err_flags;
   logic        first_valid;
   logic [3:0]  first_code;
   logic [31:0] first_cycle;

   int n_chk = 0;
   int n_err = 0;
   int edge_n = 0;

   sdram_cmd_monitor u_sdram_cmd_monitor (
      .clk (clk), .rst_n (rst_n), .cke (cke), .cs_n (cs_n), .ras_n (ras_n),
      .cas_n (cas_n), .we_n (we_n), .ba (ba), .addr (addr),
      .refresh_limit (refresh_limit), .err_mask (err_mask), .clear (clear),
      .err_flags (err_flags), .first_valid (first_valid),
      .first_code (first_code), .first_cycle (first_cycle)
   );

   always #(PERIOD / 2) clk = ~clk;

   always @(posedge clk) edge_n <= rst_n ? edge_n + 1 : 0;

   task automatic chk(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick(input logic [3:0] c, input int b, input int a);
      {cs_n, ras_n, cas_n, we_n} = c;
      ba   = b[1:0];
      addr = a[12:0];
      @(negedge clk);
      {cs_n, ras_n, cas_n, we_n} = K_NOP;
      addr = '0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) tick(K_NOP, 0, 0);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      clear = 1'b0;
      cke = 1'b1;
      err_mask = '1;
      refresh_limit = 16'd1040;
      idle(2);
      rst_n = 1'b1;
   endtask

   task automatic chk_first(input string tag, input int code, input int cyc);
      chk({tag, " first_valid"}, first_valid, code != 0);
      chk({tag, " first_code"}, first_code, code);
      if (code != 0) chk({tag, " first_cycle"}, first_cycle, cyc);
   endtask

   initial begin
      #(PERIOD * 200000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      int t0, t1, t2;
      int ef, fc, fy, bl;
      @(negedge clk);
      do_reset();
      chk("R11 reset flags", err_flags, 0);
      chk_first("R12 reset", 0, 0);

      // R2 R5 R6: activate / precharge / activate spacing sweep on bank 0
      for (int a = 1; a <= 8; a++) begin
         for (int g = a + 1; g <= 12; g++) begin
            do_reset();
            tick(K_ACT, 0, 0);
            idle(a - 1);
            t1 = edge_n;
            tick(K_PRE, 0, 0);
            idle(g - a - 1);
            t2 = edge_n;
            tick(K_ACT, 0, 0);
            ef = ((g < 9) ? 1 : 0) | ((a < 6) ? 8 : 0) | (((g - a) < 3) ? 16 : 0);
            chk($sformatf("R2 R5 R6 flags a=%0d g=%0d", a, g), err_flags, ef);
            if (a < 6) begin fc = 4; fy = t1; end
            else if (g < 9) begin fc = 1; fy = t2; end
            else if ((g - a) < 3) begin fc = 5; fy = t2; end
            else begin fc = 0; fy = 0; end
            chk_first($sformatf("R12 sweep a=%0d g=%0d", a, g), fc, fy);
         end
      end

      // R3: activate to another bank
      for (int g = 1; g <= 4; g++) begin
         do_reset();
         tick(K_ACT, 0, 0);
         idle(g - 1);
         tick(K_ACT, 1, 0);
         chk($sformatf("R3 g=%0d", g), err_flags, (g < 2) ? 2 : 0);
      end

      // R4: read / write after activate
      for (int g = 1; g <= 5; g++) begin
         do_reset();
         tick(K_ACT, 2, 0);
         idle(g - 1);
         tick((g % 2) ? K_RD : K_WR, 2, 0);
         chk($sformatf("R4 g=%0d", g), err_flags, (g < 3) ? 4 : 0);
      end

      // R8: command after mode set
      for (int g = 1; g <= 3; g++) begin
         do_reset();
         tick(K_MRS, 0, 0);
         idle(g - 1);
         tick(K_ACT, 0, 0);
         chk($sformatf("R8 g=%0d", g), err_flags, (g < 2) ? 64 : 0);
      end

      // R1: deselect carrying a mode-set pattern is no command
      do_reset();
      tick(K_MRS, 0, 0);
      tick(K_DES, 0, 0);
      chk("R1 deselect after mode set", err_flags, 0);
      cke = 1'b0;
      tick(K_MRS, 0, 0);
      cke = 1'b1;
      chk("R1 cke low mode set ignored", err_flags, 0);

      // R7 R13: refresh and mode set while open; all-bank precharge
      do_reset();
      tick(K_ACT, 3, 0);
      idle(7);
      tick(K_REF, 0, 0);
      chk("R7 R13 refresh while open", err_flags, 32);
      do_reset();
      tick(K_ACT, 1, 0);
      idle(7);
      tick(K_MRS, 0, 0);
      chk("R7 mode set while open", err_flags, 32);
      do_reset();
      tick(K_ACT, 3, 0);
      idle(7);
      tick(K_PRE, 0, AP);
      idle(4);
      tick(K_REF, 0, 0);
      chk("R7 R13 all-bank precharge closes", err_flags, 0);

      // R9: auto-precharge burst collision, BL from mode set
      for (int c = 0; c <= 3; c++) begin
         bl = 1 << c;
         for (int d = 1; d <= 9; d++) begin
            do_reset();
            tick(K_MRS, 0, c);
            idle(2);
            tick(K_ACT, 1, 0);
            idle(3);
            tick(K_RD, 1, AP);
            idle(d - 1);
            tick(K_RD, 1, 0);
            chk($sformatf("R9 bl=%0d d=%0d", bl, d), err_flags, (d < bl) ? 128 : 0);
         end
      end
      do_reset();
      tick(K_MRS, 0, 7);
      idle(2);
      tick(K_ACT, 1, 0);
      idle(3);
      tick(K_WR, 1, AP);
      idle(99);
      tick(K_WR, 1, 0);
      chk("R9 full page burst", err_flags, 128);

      // R6: reopen after auto-precharge end (BL=4)
      for (int g = 1; g <= 4; g++) begin
         do_reset();
         tick(K_MRS, 0, 2);
         idle(2);
         tick(K_ACT, 0, 0);
         idle(3);
         tick(K_RD, 0, AP);
         idle(3 + g);
         tick(K_ACT, 0, 0);
         chk($sformatf("R6 after burst g=%0d", g), err_flags, (g < 3) ? 16 : 0);
      end

      // R10: refresh gap around the limit
      for (int k = 0; k < 4; k++) begin
         int g;
         g = (k == 0) ? 19 : (k == 1) ? 20 : (k == 2) ? 21 : 30;
         do_reset();
         refresh_limit = 16'd20;
         t0 = edge_n;
         tick(K_REF, 0, 0);
         idle(g - 1);
         tick(K_REF, 0, 0);
         idle(1);
         chk($sformatf("R10 gap=%0d", g), err_flags, (g > 20) ? 256 : 0);
         chk_first($sformatf("R10 R12 gap=%0d", g), (g > 20) ? 9 : 0, t0 + 21);
      end

      // R11: mask and clear
      do_reset();
      err_mask = 9'h1FD;
      tick(K_ACT, 0, 0);
      tick(K_ACT, 1, 0);
      chk("R11 masked flag", err_flags, 0);
      chk_first("R11 masked first", 0, 0);
      err_mask = '1;
      idle(3);
      tick(K_ACT, 2, 0);
      tick(K_ACT, 3, 0);
      chk("R11 unmasked flag", err_flags, 2);
      idle(3);
      chk("R11 flag held", err_flags, 2);
      clear = 1'b1;
      idle(1);
      clear = 1'b0;
      chk("R11 cleared", err_flags, 0);
      chk_first("R12 cleared", 0, 0);

      // R12: first error frozen across a later one
      do_reset();
      tick(K_ACT, 0, 0);
      t1 = edge_n;
      tick(K_ACT, 1, 0);
      tick(K_RD, 1, 0);
      idle(2);
      chk("R12 two errors flags", err_flags, 6);
      chk_first("R12 frozen", 2, t1);

      // R1 R3: activate with cke low is ignored
      do_reset();
      tick(K_ACT, 0, 0);
      cke = 1'b0;
      tick(K_ACT, 1, 0);
      cke = 1'b1;
      idle(8);
      tick(K_REF, 0, 0);
      chk("R1 cke low activate ignored", err_flags, 32);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule